// File: doc/BRIEF.md
# Single-Bus Microsequenced CPU Core

This block is a small processor core in which every register transfer crosses one shared internal bus. A program counter, an instruction register, a memory address register, a memory data register, four general-purpose registers and two ALU operand latches (S and T) hang off that bus. The ALU result is itself one of the bus sources. A hardwired sequencer picks exactly one bus source per cycle and raises the load enables of the registers that should capture the bus value. It runs a three-cycle fetch and then a short execute sequence for each instruction.

There is no separate incrementer and no multi-ported register file. The program counter advances by passing through latch S and the ALU. A register increment or add is broken into single-source bus cycles in the same way. Instruction memory is external: the core presents the address held in MAR and expects the word at that address back combinationally on the read data port. The bus value and the one-hot source select are brought out as a trace port. A `done` flag reports that a halt instruction has been executed.

Top module: `bcpu_core`

## Requirements
- R1: While reset is asserted, and after it is released until the first fetch cycle ends, the PC, IR, MAR, MDR, S, T and all general-purpose registers hold 0. The sequencer sits in the first fetch cycle, so the bus carries PC (value 0) with the PC source selected, and `done` is low. Reset is applied asynchronously and released through a two-stage synchronizer.
- R2: `bus_src` is one-hot while the core runs. Bit 0 selects PC, bit 1 selects MDR, bit 2 selects the ALU output, and bit 3+k selects general-purpose register k. `bus_data` equals the selected source.
- R3: A fetch takes three cycles. Cycle 1 puts PC on the bus and loads it into MAR and S. Cycle 2 puts S+1 from the ALU on the bus, loads it into PC, and captures `mem_rdata` into MDR while `mem_addr` shows the old PC. Cycle 3 puts MDR on the bus and loads it into IR.
- R4: The instruction word layout is as follows. Bits [5:4] hold the opcode: 00 is add, 01 is increment, 10 is no-op and 11 is halt. Bits [3:2] hold the destination register Rd and bits [1:0] hold the source register Rs.
- R5: Add runs in three execute cycles. Cycle 1 drives Rd onto the bus into S. Cycle 2 drives Rs onto the bus into T. Cycle 3 drives the ALU sum S+T onto the bus and writes it into Rd. The sum wraps modulo 2^DATA_W, and with Rd equal to Rs the register is doubled.
- R6: Increment runs in two execute cycles. Cycle 1 drives Rd onto the bus into S. Cycle 2 drives S+1 from the ALU onto the bus and writes it into Rd. The result wraps from all-ones to 0.
- R7: A no-op has no execute cycles, and the next fetch begins in the cycle right after its IR load.
- R8: After a halt is fetched, `done` stays high and `bus_src` stays 0 until reset. No further fetch takes place.
- R9: Every write of the PC or a general-purpose register takes its value from the ALU output on the bus.
- R10: The PC advances by exactly one per fetch and wraps from all-ones to 0.
- R11: S and T are never loaded in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | DATA_W | Read address, the content of MAR |
| mem_rdata | input | DATA_W | Word at `mem_addr`, valid in the same cycle |
| bus_data | output | DATA_W | Value on the internal bus |
| bus_src | output | 3+GPR_N | One-hot bus source select |
| done | output | 1 | High once a halt has been executed |

## Verification
Some rules hold on every cycle, and the embedded assertions check them each cycle. They cover:
- a single bus source while the core runs and none once it has halted;
- MAR loading only from the PC;
- PC and register writes coming only from the ALU;
- the PC stepping by one;
- S and T never loading together;
- `done` never dropping.

Other behaviour needs whole programs, and only the bench's scenarios can show it. The bench runs a program that covers:
- every Rd/Rs add pairing, including self-doubling;
- add and increment overflow;
- no-op spacing;
- a PC wrap that lands on a halt.

It compares the source and value on the bus in every cycle against a cycle schedule computed from an instruction-level model.

// File: rtl/bcpu_pkg.sv
package bcpu_pkg;

  typedef enum logic [2:0] {
    ST_F0, ST_F1, ST_F2, ST_X0, ST_X1, ST_X2, ST_HALT
  } seq_state_e;

  // bus source positions inside the one-hot select
  localparam int SRC_PC   = 0;
  localparam int SRC_MDR  = 1;
  localparam int SRC_ALU  = 2;
  localparam int SRC_GPR0 = 3;

  localparam logic [1:0] OP_ADD  = 2'b00;
  localparam logic [1:0] OP_INC  = 2'b01;
  localparam logic [1:0] OP_NOP  = 2'b10;
  localparam logic [1:0] OP_HALT = 2'b11;

  typedef struct packed {
    logic ld_mar;
    logic ld_mdr;
    logic ld_ir;
    logic ld_pc;
    logic ld_s;
    logic ld_t;
    logic alu_inc;
  } ctl_t;

endpackage

// File: rtl/bcpu_rst_sync.sv
module bcpu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/bcpu_seq.sv
module bcpu_seq
  import bcpu_pkg::*;
#(
  parameter int GPR_N = 4,
  localparam int RIDX_W = $clog2(GPR_N),
  localparam int NSRC = SRC_GPR0 + GPR_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fetch_op,
  input  logic [1:0]        ir_op,
  input  logic [RIDX_W-1:0] ir_rd,
  input  logic [RIDX_W-1:0] ir_rs,
  output logic [NSRC-1:0]   src_sel,
  output ctl_t              ctl,
  output logic [GPR_N-1:0]  gpr_we,
  output logic              done
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    src_sel = '0;
    ctl     = '0;
    gpr_we  = '0;
    unique case (state_q)
      ST_F0: begin
        src_sel[SRC_PC] = 1'b1;
        ctl.ld_mar = 1'b1;
        ctl.ld_s   = 1'b1;
        state_d    = ST_F1;
      end
      ST_F1: begin
        src_sel[SRC_ALU] = 1'b1;
        ctl.alu_inc = 1'b1;
        ctl.ld_pc   = 1'b1;
        ctl.ld_mdr  = 1'b1;
        state_d     = ST_F2;
      end
      ST_F2: begin
        src_sel[SRC_MDR] = 1'b1;
        ctl.ld_ir = 1'b1;
        unique case (fetch_op)
          OP_ADD, OP_INC: state_d = ST_X0;
          OP_NOP:         state_d = ST_F0;
          default:        state_d = ST_HALT;
        endcase
      end
      ST_X0: begin
        src_sel[SRC_GPR0 + int'(ir_rd)] = 1'b1;
        ctl.ld_s = 1'b1;
        state_d  = ST_X1;
      end
      ST_X1: begin
        if (ir_op == OP_INC) begin
          src_sel[SRC_ALU] = 1'b1;
          ctl.alu_inc   = 1'b1;
          gpr_we[ir_rd] = 1'b1;
          state_d       = ST_F0;
        end else begin
          src_sel[SRC_GPR0 + int'(ir_rs)] = 1'b1;
          ctl.ld_t = 1'b1;
          state_d  = ST_X2;
        end
      end
      ST_X2: begin
        src_sel[SRC_ALU] = 1'b1;
        gpr_we[ir_rd] = 1'b1;
        state_d       = ST_F0;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_F0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_F0;
    else        state_q <= state_d;
  end

  assign done = (state_q == ST_HALT);

  assert_one_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $onehot(src_sel));
  assert_idle_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (src_sel == '0));
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  assert_latch_split_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.ld_s && ctl.ld_t));
endmodule

// File: rtl/bcpu_datapath.sv
module bcpu_datapath
  import bcpu_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int GPR_N  = 4,
  localparam int NSRC = SRC_GPR0 + GPR_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_sel,
  input  ctl_t              ctl,
  input  logic [GPR_N-1:0]  gpr_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] bus,
  output logic [DATA_W-1:0] mar_q,
  output logic [DATA_W-1:0] mdr_q,
  output logic [DATA_W-1:0] ir_q
);
  logic [DATA_W-1:0] pc_q, s_q, t_q, alu_y;
  logic [DATA_W-1:0] gpr_q [GPR_N];

  // single adder: second operand is T or the constant one
  assign alu_y = s_q + (ctl.alu_inc ? DATA_W'(1) : t_q);

  // AND-OR bus multiplexer driven by the one-hot select
  always_comb begin
    bus = '0;
    if (src_sel[SRC_PC])  bus = bus | pc_q;
    if (src_sel[SRC_MDR]) bus = bus | mdr_q;
    if (src_sel[SRC_ALU]) bus = bus | alu_y;
    for (int k = 0; k < GPR_N; k++)
      if (src_sel[SRC_GPR0 + k]) bus = bus | gpr_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc_q <= '0;
    else if (ctl.ld_pc)  pc_q <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mar_q <= '0;
    else if (ctl.ld_mar) mar_q <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mdr_q <= '0;
    else if (ctl.ld_mdr) mdr_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ir_q <= '0;
    else if (ctl.ld_ir)  ir_q <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          s_q <= '0;
    else if (ctl.ld_s)   s_q <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          t_q <= '0;
    else if (ctl.ld_t)   t_q <= bus;
  end

  for (genvar k = 0; k < GPR_N; k++) begin : g_gpr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         gpr_q[k] <= '0;
      else if (gpr_we[k]) gpr_q[k] <= bus;
    end
  end

  assert_write_via_alu_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gpr_we) || ctl.ld_pc) |-> src_sel[SRC_ALU]);
  assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ld_pc |=> (pc_q == DATA_W'($past(pc_q) + DATA_W'(1))));
  assert_mar_from_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ld_mar |-> src_sel[SRC_PC]);
endmodule

// File: rtl/bcpu_core.sv
module bcpu_core
  import bcpu_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int GPR_N  = 4,
  localparam int RIDX_W = $clog2(GPR_N),
  localparam int NSRC = SRC_GPR0 + GPR_N,
  localparam int RS_LSB = 0,
  localparam int RD_LSB = RIDX_W,
  localparam int OP_LSB = 2 * RIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] bus_data,
  output logic [NSRC-1:0]   bus_src,
  output logic              done
);
  logic              core_rst_n;
  ctl_t              ctl;
  logic [GPR_N-1:0]  gpr_we;
  logic [DATA_W-1:0] mdr_q, ir_q;

  bcpu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  bcpu_seq #(.GPR_N(GPR_N)) u_seq (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .fetch_op (mdr_q[OP_LSB +: 2]),
    .ir_op    (ir_q[OP_LSB +: 2]),
    .ir_rd    (ir_q[RD_LSB +: RIDX_W]),
    .ir_rs    (ir_q[RS_LSB +: RIDX_W]),
    .src_sel  (bus_src),
    .ctl      (ctl),
    .gpr_we   (gpr_we),
    .done     (done)
  );

  bcpu_datapath #(.DATA_W(DATA_W), .GPR_N(GPR_N)) u_dp (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .src_sel   (bus_src),
    .ctl       (ctl),
    .gpr_we    (gpr_we),
    .mem_rdata (mem_rdata),
    .bus       (bus_data),
    .mar_q     (mem_addr),
    .mdr_q     (mdr_q),
    .ir_q      (ir_q)
  );
endmodule

// File: tb/bcpu_core_test.sv
module bcpu_core_test;
  localparam int W = 6;
  localparam int NS = 7;
  localparam int DEPTH = 64;
  localparam int MAXE = 1024;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [W-1:0] mem_addr, mem_rdata, bus_data;
  logic [NS-1:0] bus_src;
  logic done;
  logic [W-1:0] mem [DEPTH];

  assign mem_rdata = mem[mem_addr];

  bcpu_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .bus_data(bus_data), .bus_src(bus_src), .done(done)
  );

  int checks = 0;
  int fails = 0;

  logic [NS-1:0] e_src [MAXE];
  logic [W-1:0]  e_dat [MAXE];
  logic          e_has_addr [MAXE];
  logic [W-1:0]  e_addr [MAXE];
  string         e_tag [MAXE];
  int            n_exp = 0;

  // R4 layout: opcode [5:4], Rd [3:2], Rs [1:0]
  function automatic logic [W-1:0] enc(input logic [1:0] op, input int rd, input int rs);
    return {op, 2'(rd), 2'(rs)};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int src_bit, input logic [W-1:0] dat, input string tag);
    e_src[n_exp] = NS'(1) << src_bit;
    e_dat[n_exp] = dat;
    e_has_addr[n_exp] = 1'b0;
    e_addr[n_exp] = '0;
    e_tag[n_exp] = tag;
    n_exp++;
  endtask

  // instruction-level model producing the expected bus schedule
  task automatic build();
    logic [W-1:0] pc = '0;
    logic [W-1:0] g [4];
    logic [W-1:0] w, sum;
    bit seen0 = 0;
    bit after_nop = 0;
    bit halted = 0;
    int rd, rs;
    for (int k = 0; k < 4; k++) g[k] = '0;
    while (!halted && n_exp < MAXE - 8) begin
      push(0, pc, after_nop ? "R7" : ((pc == 0 && seen0) ? "R10" : "R3"));
      after_nop = 0;
      push(2, pc + 1'b1, "R9");
      e_has_addr[n_exp-1] = 1'b1;
      e_addr[n_exp-1] = pc;
      w = (pc == 0 && seen0) ? enc(2'b11, 0, 0) : mem[pc];
      if (pc == 0) seen0 = 1;
      pc = pc + 1'b1;
      push(1, w, "R3");
      rd = int'(w[3:2]);
      rs = int'(w[1:0]);
      case (w[5:4])
        2'b00: begin
          push(3 + rd, g[rd], "R5");
          push(3 + rs, g[rs], "R5");
          sum = g[rd] + g[rs];
          push(2, sum, "R5");
          g[rd] = sum;
        end
        2'b01: begin
          push(3 + rd, g[rd], "R6");
          g[rd] = g[rd] + 1'b1;
          push(2, g[rd], "R6");
        end
        2'b10: after_nop = 1;
        default: halted = 1;
      endcase
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int a;
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) mem[i] = enc(2'b10, 0, 0);
    a = 1;
    mem[a++] = enc(2'b01, 1, 0);
    for (int i = 0; i < 2; i++) mem[a++] = enc(2'b01, 2, 0);
    for (int i = 0; i < 3; i++) mem[a++] = enc(2'b01, 3, 0);
    for (int i = 0; i < 5; i++) mem[a++] = enc(2'b01, 0, 0);
    // every Rd/Rs pairing of add (R5), self pairs double
    for (int rd = 0; rd < 4; rd++)
      for (int rs = 0; rs < 4; rs++) mem[a++] = enc(2'b00, rd, rs);
    // six doublings clear a 6-bit register through add overflow
    for (int i = 0; i < 6; i++) mem[a++] = enc(2'b00, 2, 2);
    for (int i = 0; i < 6; i++) mem[a++] = enc(2'b00, 3, 3);
    mem[a++] = enc(2'b01, 2, 0);
    mem[a++] = enc(2'b00, 3, 2);
    for (int i = 0; i < 5; i++) begin
      mem[a++] = enc(2'b00, 2, 2);
      mem[a++] = enc(2'b00, 3, 2);
    end
    // R3 now all ones: increment wraps to zero (R6)
    mem[a++] = enc(2'b01, 3, 0);
    build();

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < 2; r++) begin
      #1;
      chk("R1", "reset bus_src", 32'(bus_src), 32'(1));
      chk("R1", "reset bus_data", 32'(bus_data), 32'(0));
      chk("R1", "reset done", 32'(done), 32'(0));
      @(negedge clk);
    end

    for (int i = 0; i < n_exp; i++) begin
      #1;
      chk({e_tag[i], " R2"}, $sformatf("bus_src step %0d", i), 32'(bus_src), 32'(e_src[i]));
      chk(e_tag[i], $sformatf("bus_data step %0d", i), 32'(bus_data), 32'(e_dat[i]));
      if (e_has_addr[i])
        chk("R3", $sformatf("mem_addr step %0d", i), 32'(mem_addr), 32'(e_addr[i]));
      chk("R8", $sformatf("done low step %0d", i), 32'(done), 32'(0));
      // after the first fetch from address 0, plant a halt there for the wrap
      if (i == 3) mem[0] = enc(2'b11, 0, 0);
      @(negedge clk);
    end

    for (int i = 0; i < 5; i++) begin
      #1;
      chk("R8", "done after halt", 32'(done), 32'(1));
      chk("R8", "idle bus after halt", 32'(bus_src), 32'(0));
      @(negedge clk);
    end
    finish_run();
  end
endmodule